// File: doc/BRIEF.md
# Two-Thread Gshare Branch Direction Predictor

This block predicts whether a conditional branch will be taken, for a core that runs two hardware threads at once. Every thread owns a private global history register and a private table of two-bit saturating counters. A branch is looked up by combining the word-address bits of its program counter with that thread's history through XOR. The counter found there gives the direction, so a thread's branches never change another thread's predictions.

The front end presents a thread id and PC on the predict port. It gets back the predicted direction and the history value used for the lookup, both in the same cycle. When the branch resolves, the core sends back the thread id, the PC, that saved history value and the real outcome. The block then trains the counter that the saved history selects. It also rebuilds the thread's history from the saved value plus the real outcome, which repairs any wrong-path history at the same time. The total storage is 4K counters: with the default 11-bit history, each of the two threads has 2K.

Top module: `smt_gshare_pred`

## Requirements
- R1: After reset, every thread's history reads 0 and every counter holds 01 (weakly not-taken), so every prediction is not-taken.
- R2: The lookup index for a thread is PC[HIST_W+1:2] XOR that thread's history; with defaults, PC[12:2] XOR an 11-bit history.
- R3: `pred_taken` equals bit 1 (MSB) of the indexed counter and responds in the same cycle as the predict inputs.
- R4: An update with outcome taken increments the counter at index PC[HIST_W+1:2] XOR `upd_hist`, saturating at 3.
- R5: An update with outcome not-taken decrements that counter, saturating at 0.
- R6: On an update, the thread's history becomes {`upd_hist`[HIST_W-2:0], outcome}, with the outcome in bit 0 (1 = taken). The new value shows on `pred_hist` from the next cycle.
- R7: An update for one thread leaves the other thread's counters and history unchanged.
- R8: `pred_hist` shows the current history of the thread selected by `pred_tid`. With no update for that thread, it holds its value.
- R9: PC bits outside [HIST_W+1:2] have no effect on the prediction.
- R10: Counter and history changes take effect at the clock edge after the update. A prediction made in the same cycle as an update sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_tid | input | 1 | Thread issuing the lookup |
| pred_pc | input | 32 | Branch PC to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | 11 | History used for this lookup, returned later with the update |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_tid | input | 1 | Thread of the resolved branch |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_hist | input | 11 | History value captured at prediction time |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A corrupted history register shows on `pred_hist` in the cycle after the update that wrote it. It also sends every later lookup of that thread to the wrong counter. A counter that misses its saturation limit, or wraps, shows only when that entry is predicted again. It flips the predicted direction one update after the limit should have held. A leak between threads shows as a changed prediction or history on the idle thread in the cycle right after the other thread's update.

// File: rtl/bp_pkg.sv
// Shared types and constants for the two-thread gshare predictor.
// Assumes two-bit counters; the encoding is fixed by the requirements.
package bp_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN   = 2'b00;
    localparam ctr_t CTR_RESET = 2'b01;
    localparam ctr_t CTR_MAX   = 2'b11;
endpackage

// File: rtl/bp_sat_ctr.sv
// Next-state logic of one two-bit saturating counter.
// Assumes the caller only uses the output when an update is valid.
module bp_sat_ctr
    import bp_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);
    // Move toward the outcome, pinned at both ends.
    always_comb begin
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 2'd1;
        end
    end
endmodule

// File: rtl/bp_hist_reg.sv
// Global history register of one thread.
// Assumes the parent builds the restored and shifted value.
module bp_hist_reg #(
    parameter int HIST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [HIST_W-1:0] load_val,
    output logic [HIST_W-1:0] hist
);
    // Clear on reset; otherwise take the repaired history on update.
    always_ff @(posedge clk) begin
        if (!rst_n)       hist <= '0;
        else if (load_en) hist <= load_val;
    end
endmodule

// File: rtl/bp_ctr_table.sv
// Counter table of one thread: one combinational lookup port, plus an
// update port that reads the old value and writes the new one at the edge.
// Assumes only one write per cycle.
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_cnt,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    output ctr_t             upd_old,
    input  ctr_t             upd_new
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];

    // Lookup paths read the stored state directly.
    assign rd_cnt  = mem[rd_idx];
    assign upd_old = mem[upd_idx];

    // Reset every entry to weakly not-taken; write back trained counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RESET;
        end else if (upd_en) begin
            mem[upd_idx] <= upd_new;
        end
    end
endmodule

// File: rtl/smt_gshare_pred.sv
// Two-thread gshare direction predictor. Each thread owns its history and
// counter table; index = PC word bits XOR that thread's history.
// Assumes PC_W >= HIST_W + 2 and a single update per cycle.
module smt_gshare_pred
    import bp_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int PC_W    = 32,
    parameter int HIST_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_tid,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic              upd_tid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken
);
    localparam int LO = 2;
    localparam int HI = HIST_W + 1;

    logic [HIST_W-1:0] hist_all [THREADS];
    ctr_t              rd_all   [THREADS];
    ctr_t              old_all  [THREADS];
    logic [HIST_W-1:0] pred_idx;
    logic [HIST_W-1:0] upd_idx;
    logic [HIST_W-1:0] hist_next;
    ctr_t              upd_old_cnt;
    ctr_t              upd_new_cnt;
    logic              unused_pc_bits;

    // Hash the lookup and update PCs with their histories.
    assign pred_hist = hist_all[pred_tid];
    assign pred_idx  = pred_pc[HI:LO] ^ pred_hist;
    assign upd_idx   = upd_pc[HI:LO] ^ upd_hist;
    assign hist_next = {upd_hist[HIST_W-2:0], upd_taken};

    // Pick the indexed counter of the right thread.
    assign pred_taken  = rd_all[pred_tid][1];
    assign upd_old_cnt = old_all[upd_tid];

    assign unused_pc_bits = ^{pred_pc[PC_W-1:HI+1], pred_pc[LO-1:0],
                              upd_pc[PC_W-1:HI+1],  upd_pc[LO-1:0]};

    bp_sat_ctr u_sat (
        .cur   (upd_old_cnt),
        .taken (upd_taken),
        .nxt   (upd_new_cnt)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic hit;
        assign hit = upd_valid && (upd_tid == 1'(t));

        bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (hit),
            .load_val (hist_next),
            .hist     (hist_all[t])
        );

        bp_ctr_table #(.IDX_W(HIST_W)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (pred_idx),
            .rd_cnt  (rd_all[t]),
            .upd_en  (hit),
            .upd_idx (upd_idx),
            .upd_old (old_all[t]),
            .upd_new (upd_new_cnt)
        );
    end
endmodule

// File: rtl/smt_gshare_pred_chk.sv
// Protocol checker for smt_gshare_pred, attached by bind.
module smt_gshare_pred_chk
    import bp_pkg::*;
#(
    parameter int HIST_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_tid,
    input logic              pred_taken,
    input logic [HIST_W-1:0] pred_hist,
    input logic              upd_valid,
    input logic              upd_tid,
    input logic [HIST_W-1:0] upd_hist,
    input logic              upd_taken,
    input ctr_t              upd_old_cnt,
    input ctr_t              upd_new_cnt
);
    // R1: first cycle out of reset shows cleared state.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pred_hist == '0 && !pred_taken));

    // R4: taken never lowers a counter and holds it at 3.
    p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_old_cnt == CTR_MAX) |-> upd_new_cnt == CTR_MAX);

    // R5: not-taken holds a counter at 0.
    p_sat_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_old_cnt == CTR_MIN) |-> upd_new_cnt == CTR_MIN);

    // R6: history shows the restored, shifted value a cycle after update.
    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(rst_n)) |=> (pred_tid != $past(upd_tid)) ||
            (pred_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)}));

    // R7/R8: a thread with no update of its own keeps its history.
    p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid || upd_tid != pred_tid) |=>
            (pred_tid != $past(pred_tid)) || $stable(pred_hist));
endmodule

bind smt_gshare_pred smt_gshare_pred_chk #(.HIST_W(HIST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_tid    (pred_tid),
    .pred_taken  (pred_taken),
    .pred_hist   (pred_hist),
    .upd_valid   (upd_valid),
    .upd_tid     (upd_tid),
    .upd_hist    (upd_hist),
    .upd_taken   (upd_taken),
    .upd_old_cnt (upd_old_cnt),
    .upd_new_cnt (upd_new_cnt)
);

// File: tb/smt_gshare_pred_tb_top.sv
module smt_gshare_pred_tb_top;
    localparam int HW = 11;
    localparam int N  = 1 << HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_tid = 1'b0;
    logic [31:0]   pred_pc = '0;
    logic          pred_taken;
    logic [HW-1:0] pred_hist;
    logic          upd_valid = 1'b0;
    logic          upd_tid = 1'b0;
    logic [31:0]   upd_pc = '0;
    logic [HW-1:0] upd_hist = '0;
    logic          upd_taken = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [1:0]    m_cnt [2][N];
    logic [HW-1:0] m_hist [2];

    always #4 clk = ~clk;

    smt_gshare_pred dut_i (
        .clk(clk), .rst_n(rst_n),
        .pred_tid(pred_tid), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_hist(pred_hist),
        .upd_valid(upd_valid), .upd_tid(upd_tid), .upd_pc(upd_pc),
        .upd_hist(upd_hist), .upd_taken(upd_taken)
    );

    function automatic logic [HW-1:0] idx_of(logic [31:0] pc, logic [HW-1:0] h);
        return pc[HW+1:2] ^ h;
    endfunction

    function automatic logic [1:0] sat_next(logic [1:0] c, logic t);
        if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < 2; t++) begin
            m_hist[t] = '0;
            for (int i = 0; i < N; i++) m_cnt[t][i] = 2'b01;
        end
    endtask

    // Drive one cycle at the falling edge; check the lookup; train model.
    task automatic step(input logic ptid, input logic [31:0] ppc,
                        input logic uv, input logic utid, input logic [31:0] upc,
                        input logic [HW-1:0] uh, input logic ut, input string req);
        logic [1:0] ec;
        @(negedge clk);
        pred_tid = ptid; pred_pc = ppc;
        upd_valid = uv; upd_tid = utid; upd_pc = upc; upd_hist = uh; upd_taken = ut;
        #1;
        ec = m_cnt[ptid][idx_of(ppc, m_hist[ptid])];
        chk(pred_taken == ec[1], req, pred_taken, ec[1]);
        chk(pred_hist == m_hist[ptid], {req, "/R8 hist"}, pred_hist, m_hist[ptid]);
        @(posedge clk);
        if (uv) begin
            m_cnt[utid][idx_of(upc, uh)] = sat_next(m_cnt[utid][idx_of(upc, uh)], ut);
            m_hist[utid] = {uh[HW-2:0], ut};
        end
    endtask

    // PC that reaches entry i of a thread under the model's current history.
    function automatic logic [31:0] pc_for(logic tid, logic [HW-1:0] i);
        return {19'd0, i ^ m_hist[tid], 2'b00};
    endfunction

    task automatic train(input logic tid, input logic [HW-1:0] i, input logic t);
        step(tid, 32'h0, 1'b1, tid, {19'd0, i, 2'b00}, '0, t, "R3 train");
    endtask

    task automatic probe(input logic tid, input logic [HW-1:0] i, input logic exp, input string req);
        @(negedge clk);
        upd_valid = 1'b0; pred_tid = tid; pred_pc = pc_for(tid, i);
        #1;
        chk(pred_taken == exp, req, pred_taken, exp);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] pc_set [8];
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: cleared state on both threads.
        for (int k = 0; k < 4; k++)
            step(k[0], $urandom, 1'b0, 1'b0, 32'h0, '0, 1'b0, "R1 reset");

        // R4: climb past 3; one not-taken then leaves 2 (taken).
        for (int k = 0; k < 5; k++) train(1'b0, 11'h155, 1'b1);
        train(1'b0, 11'h155, 1'b0);
        probe(1'b0, 11'h155, 1'b1, "R4 saturate at 3");

        // R5: fall past 0; one taken then leaves 1 (not-taken).
        for (int k = 0; k < 5; k++) train(1'b0, 11'h0AA, 1'b0);
        train(1'b0, 11'h0AA, 1'b1);
        probe(1'b0, 11'h0AA, 1'b0, "R5 saturate at 0");

        // R7: thread 1 untouched by thread 0 training.
        probe(1'b1, 11'h155, 1'b0, "R7 isolation counter");
        @(negedge clk); pred_tid = 1'b1; #1;
        chk(pred_hist == '0, "R7 isolation hist", pred_hist, 0);

        // R10: same-cycle predict sees the old counter.
        train(1'b1, 11'h333, 1'b1);
        step(1'b1, pc_for(1'b1, 11'h333), 1'b1, 1'b1, {19'd0, 11'h333, 2'b00}, '0, 1'b1, "R10 old state");
        probe(1'b1, 11'h333, 1'b1, "R10 new state");

        // R9: high and low PC bits ignored.
        step(1'b1, pc_for(1'b1, 11'h333) | 32'hFFFF_E003, 1'b0, 1'b0, 32'h0, '0, 1'b0, "R9 ignored bits");

        // R2/R6: history restore with an arbitrary supplied value.
        step(1'b0, 32'h0, 1'b1, 1'b0, 32'h40, 11'h5A5, 1'b1, "R6 restore");
        step(1'b0, 32'h1234, 1'b0, 1'b0, 32'h0, '0, 1'b0, "R6 shifted hist");

        // Random mix over a small PC set for aliasing and training.
        for (int k = 0; k < 8; k++) pc_set[k] = $urandom;
        for (int k = 0; k < 3000; k++) begin
            logic ptid, utid, t;
            logic [31:0] ppc, upc;
            logic [HW-1:0] uh;
            ptid = 1'($urandom);
            utid = 1'($urandom);
            ppc  = pc_set[$urandom % 8];
            upc  = pc_set[$urandom % 8];
            t    = ($urandom % 4) != 0;
            uh   = (($urandom % 5) == 0) ? HW'($urandom) : m_hist[utid];
            step(ptid, ppc, ($urandom % 3) != 0, utid, upc, uh, t, "R2 R3 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule